// File: doc/BRIEF.md
# LCD Frame Timing and Display-Mode Controller

This block generates the two timing strobes an external LCD column driver needs: a line-sync clock that steps through the common rows, and a frame-polarity signal that flips once for each complete scan of the rows. Both come from one free-running counter on the low-frequency base clock. The counter is 32.768 kHz in the target, although the logic only counts edges. A two-bit duty select chooses 32, 16 or 8 common rows. The line-sync rate follows from that choice. The frame-polarity period always covers twice the row count in line-sync periods.

The block also holds the display-mode code and the contrast code. It decodes the mode into the status flags that the segment and common drivers consume: static common drive, drive enable, forced all-on and forced all-off. The forced flags override the displayed pattern without touching display memory. A sleep input forces the mode to drive-off. An external-supply strap overrides the contrast code with a fixed value. The two strobes reach their general-purpose output pins through a per-pin enable and a per-pin port data bit. A disabled strobe leaves its pin idling high.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: Mode code encoding is 11 = all dots on, 10 = all dots off, 01 = normal, 00 = drive off. With `mode_we` high, `mode_wdata` is stored at the clock edge and appears on `disp_mode` one cycle later. Without a write or sleep, the code holds.
- R2: `sleep` high forces `disp_mode` to 00 at the next edge and takes priority over a simultaneous mode write.
- R3: `static_com` and `dots_all_on` are 1 only in mode 11, `dots_all_off` is 1 only in mode 10, and `drive_en` is 0 only in mode 00. All four update in the same cycle as `disp_mode`.
- R4: With `contrast_we` high, the 4-bit `contrast_wdata` is stored. Level 0 is the lightest and 15 the darkest. With `ext_supply` low, `contrast_out` shows the stored code one cycle after the write.
- R5: With `ext_supply` high, `contrast_out` shows the fixed value `FIXED_CONTRAST` (default 0) one cycle later. The stored code is kept and shows again once `ext_supply` returns low.
- R6: Duty select encoding is 00 = 1/32, 01 = 1/16, 10 or 11 = 1/8. The line-sync strobe is bit 3, 4 or 5 of the counter respectively, giving a square wave with a period of 16, 32 or 64 base clocks. These are 2048, 1024 and 512 Hz at 32.768 kHz.
- R7: The frame-polarity strobe is bit 9 of the counter. Its period is 1024 base clocks (32 Hz) for every duty, which equals twice the row count in line-sync periods.
- R8: The 10-bit counter is cleared by reset and by any change of the duty select, and increments otherwise. Each pin is registered from the counter value of the previous cycle.
- R9: Each pin equals data AND (enable ? strobe : 1), registered. Reset drives both pins high.
- R10: Enable and data bits are used without synchronization to the strobe phase. A change reaches the pin at the next edge, even mid-phase, so a truncated first or last pulse is possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_sel | input | 2 | Drive duty select |
| sleep | input | 1 | Sleep request, forces drive-off |
| mode_we | input | 1 | Mode code write strobe |
| mode_wdata | input | 2 | Mode code to write |
| contrast_we | input | 1 | Contrast code write strobe |
| contrast_wdata | input | 4 | Contrast code to write |
| ext_supply | input | 1 | External LCD supply strap |
| cl_en | input | 1 | Line-sync pin enable |
| cl_data | input | 1 | Line-sync pin port data bit |
| fr_en | input | 1 | Frame-polarity pin enable |
| fr_data | input | 1 | Frame-polarity pin port data bit |
| cl_pin | output | 1 | Line-sync output pin |
| fr_pin | output | 1 | Frame-polarity output pin |
| disp_mode | output | 2 | Current display-mode code |
| static_com | output | 1 | Static common drive active |
| drive_en | output | 1 | LCD drive enabled |
| dots_all_on | output | 1 | Force all dots on |
| dots_all_off | output | 1 | Force all dots off |
| contrast_out | output | 4 | Effective contrast code |

## Verification
The bench tracks the counter from the duty and reset inputs alone and compares both pins every cycle. It does this across all four duty codes and all sixteen combinations of the enable and data bits. The per-duty runs tell apart the three line-sync rates and show that the frame rate stays the same. The enable and data sweep, switched at arbitrary phases, tells apart the idle-high path, the forced-low path and the unsynchronized hand-over, and a mid-run duty change exposes a missing counter reload. Every mode code is written and its flags are decoded. A sleep that collides with a write shows the priority. All sixteen contrast codes are written with the external-supply strap both low and high.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_BLANK  = 2'b10,
    MODE_ALLON  = 2'b11
  } disp_mode_e;

  typedef enum logic [1:0] {
    DUTY_32  = 2'b00,
    DUTY_16  = 2'b01,
    DUTY_8   = 2'b10,
    DUTY_8B  = 2'b11
  } duty_e;

  typedef struct packed {
    logic static_com;
    logic drive_en;
    logic force_on;
    logic force_off;
  } mode_flags_t;

  // number of doublings of the line-sync period relative to 1/32 duty
  function automatic logic [1:0] duty_shift(input logic [1:0] d);
    case (d)
      DUTY_32: duty_shift = 2'd0;
      DUTY_16: duty_shift = 2'd1;
      default: duty_shift = 2'd2;
    endcase
  endfunction

  function automatic mode_flags_t decode_mode(input logic [1:0] m);
    mode_flags_t f;
    f.static_com = (m == MODE_ALLON);
    f.force_on   = (m == MODE_ALLON);
    f.force_off  = (m == MODE_BLANK);
    f.drive_en   = (m != MODE_OFF);
    decode_mode  = f;
  endfunction

endpackage

// File: rtl/lcdt_divider.sv
module lcdt_divider
  import lcdt_pkg::*;
#(
  parameter int BASE_DIV_LOG2 = 4,
  parameter int MAX_ROWS_LOG2 = 5,
  localparam int CNT_W = BASE_DIV_LOG2 + MAX_ROWS_LOG2 + 1,
  localparam int IDX_W = $clog2(CNT_W)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] duty_sel,
  output logic       cl_sig,
  output logic       fr_sig
);

  logic [CNT_W-1:0] tick;
  logic [1:0]       duty_q;
  logic [IDX_W-1:0] cl_idx;
  logic             duty_chg;

  assign duty_chg = (duty_sel != duty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick   <= '0;
      duty_q <= duty_sel;
    end else if (duty_chg) begin
      tick   <= '0;
      duty_q <= duty_sel;
    end else begin
      tick   <= tick + 1'b1;
    end
  end

  // line-sync bit moves up one position per halving of the row count
  always_comb begin
    cl_idx = IDX_W'(BASE_DIV_LOG2 - 1) + IDX_W'(duty_shift(duty_q));
  end

  assign cl_sig = tick[cl_idx];
  assign fr_sig = tick[CNT_W-1];

  // R8: a duty change reloads the counter at the next edge
  a_r8_duty_reload: assert property (@(posedge clk) disable iff (rst)
    duty_chg |=> (tick == '0));

  // R8: with a steady duty the counter advances by exactly one
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    (!duty_chg && !$past(rst)) |=> (tick == $past(tick) + 1'b1));

endmodule

// File: rtl/lcdt_pinmux.sv
module lcdt_pinmux #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] sig,
  input  logic [NPINS-1:0] en,
  input  logic [NPINS-1:0] data,
  output logic [NPINS-1:0] pin
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic q;

    always_ff @(posedge clk) begin
      if (rst) q <= 1'b1;
      else     q <= data[g] & (~en[g] | sig[g]);
    end

    assign pin[g] = q;

    // R9: disabled pin with data set idles high
    a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
      (data[g] && !en[g]) |=> q);

    // R9: cleared port data bit holds the pin low
    a_r9_data_low: assert property (@(posedge clk) disable iff (rst)
      !data[g] |=> !q);

    // R10: enabled pin follows the strobe in the very next cycle
    a_r10_follow: assert property (@(posedge clk) disable iff (rst)
      (data[g] && en[g]) |=> (q == $past(sig[g])));
  end

endmodule

// File: rtl/lcdt_mode_ctl.sv
module lcdt_mode_ctl
  import lcdt_pkg::*;
#(
  parameter int          CON_W          = 4,
  parameter logic [CON_W-1:0] FIXED_CONTRAST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             mode_we,
  input  logic [1:0]       mode_wdata,
  input  logic             contrast_we,
  input  logic [CON_W-1:0] contrast_wdata,
  input  logic             ext_supply,
  output logic [1:0]       disp_mode,
  output mode_flags_t      flags,
  output logic [CON_W-1:0] contrast_out
);

  logic [1:0]       mode_q, mode_nxt;
  mode_flags_t      flags_q;
  logic [CON_W-1:0] con_q, con_nxt;

  always_comb begin
    mode_nxt = mode_q;
    if (sleep)        mode_nxt = MODE_OFF;
    else if (mode_we) mode_nxt = mode_wdata;
  end

  always_comb begin
    con_nxt = contrast_we ? contrast_wdata : con_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_OFF;
      flags_q <= decode_mode(MODE_OFF);
    end else begin
      mode_q  <= mode_nxt;
      flags_q <= decode_mode(mode_nxt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      con_q        <= '0;
      contrast_out <= ext_supply ? FIXED_CONTRAST : '0;
    end else begin
      con_q        <= con_nxt;
      contrast_out <= ext_supply ? FIXED_CONTRAST : con_nxt;
    end
  end

  assign disp_mode = mode_q;
  assign flags     = flags_q;

  // R2: sleep forces drive-off regardless of a concurrent write
  a_r2_sleep_off: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (disp_mode == MODE_OFF));

  // R1: without write or sleep the mode code holds
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !mode_we) |=> $stable(disp_mode));

  // R3: static common drive only in the all-on mode
  a_r3_static_allon: assert property (@(posedge clk) disable iff (rst)
    flags.static_com |-> (disp_mode == MODE_ALLON));

  // R3: drive is disabled exactly in mode 00
  a_r3_drive_off: assert property (@(posedge clk) disable iff (rst)
    (!flags.drive_en) == (disp_mode == MODE_OFF));

  // R3: forced-on and forced-off are never both active
  a_r3_force_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flags.force_on, flags.force_off}));

  // R5: external supply pins the contrast output to the fixed level
  a_r5_fixed: assert property (@(posedge clk) disable iff (rst)
    ext_supply |=> (contrast_out == FIXED_CONTRAST));

endmodule

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
  import lcdt_pkg::*;
#(
  parameter int BASE_DIV_LOG2 = 4,
  parameter int MAX_ROWS_LOG2 = 5,
  parameter int CON_W         = 4,
  parameter logic [CON_W-1:0] FIXED_CONTRAST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       duty_sel,
  input  logic             sleep,
  input  logic             mode_we,
  input  logic [1:0]       mode_wdata,
  input  logic             contrast_we,
  input  logic [CON_W-1:0] contrast_wdata,
  input  logic             ext_supply,
  input  logic             cl_en,
  input  logic             cl_data,
  input  logic             fr_en,
  input  logic             fr_data,
  output logic             cl_pin,
  output logic             fr_pin,
  output logic [1:0]       disp_mode,
  output logic             static_com,
  output logic             drive_en,
  output logic             dots_all_on,
  output logic             dots_all_off,
  output logic [CON_W-1:0] contrast_out
);

  localparam int NPINS = 2;

  logic             cl_sig, fr_sig;
  logic [NPINS-1:0] pins;
  mode_flags_t      flags;

  lcdt_divider #(
    .BASE_DIV_LOG2 (BASE_DIV_LOG2),
    .MAX_ROWS_LOG2 (MAX_ROWS_LOG2)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .duty_sel (duty_sel),
    .cl_sig   (cl_sig),
    .fr_sig   (fr_sig)
  );

  lcdt_pinmux #(
    .NPINS (NPINS)
  ) u_mux (
    .clk  (clk),
    .rst  (rst),
    .sig  ({fr_sig, cl_sig}),
    .en   ({fr_en, cl_en}),
    .data ({fr_data, cl_data}),
    .pin  (pins)
  );

  lcdt_mode_ctl #(
    .CON_W          (CON_W),
    .FIXED_CONTRAST (FIXED_CONTRAST)
  ) u_mode (
    .clk            (clk),
    .rst            (rst),
    .sleep          (sleep),
    .mode_we        (mode_we),
    .mode_wdata     (mode_wdata),
    .contrast_we    (contrast_we),
    .contrast_wdata (contrast_wdata),
    .ext_supply     (ext_supply),
    .disp_mode      (disp_mode),
    .flags          (flags),
    .contrast_out   (contrast_out)
  );

  assign cl_pin       = pins[0];
  assign fr_pin       = pins[1];
  assign static_com   = flags.static_com;
  assign drive_en     = flags.drive_en;
  assign dots_all_on  = flags.force_on;
  assign dots_all_off = flags.force_off;

endmodule

// File: tb/sim_lcd_timing_ctrl.sv
module sim_lcd_timing_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] duty_sel = 2'b00;
  logic       sleep = 1'b0;
  logic       mode_we = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic       contrast_we = 1'b0;
  logic [3:0] contrast_wdata = 4'h0;
  logic       ext_supply = 1'b0;
  logic       cl_en = 1'b0, cl_data = 1'b1, fr_en = 1'b0, fr_data = 1'b1;
  logic       cl_pin, fr_pin, static_com, drive_en, dots_all_on, dots_all_off;
  logic [1:0] disp_mode;
  logic [3:0] contrast_out;

  int n_chk = 0;
  int n_fail = 0;
  bit pin_chk = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_timing_ctrl u0 (
    .clk(clk), .rst(rst), .duty_sel(duty_sel), .sleep(sleep),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .contrast_we(contrast_we), .contrast_wdata(contrast_wdata),
    .ext_supply(ext_supply), .cl_en(cl_en), .cl_data(cl_data),
    .fr_en(fr_en), .fr_data(fr_data), .cl_pin(cl_pin), .fr_pin(fr_pin),
    .disp_mode(disp_mode), .static_com(static_com), .drive_en(drive_en),
    .dots_all_on(dots_all_on), .dots_all_off(dots_all_off),
    .contrast_out(contrast_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Counter and pin model built from R6..R9
  logic [9:0] mt = '0;
  logic [1:0] mduty = 2'b00;
  logic       ecl = 1'b1, efr = 1'b1;

  function automatic int cl_bit(input logic [1:0] d);
    return (d == 2'b00) ? 3 : (d == 2'b01) ? 4 : 5;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mt = '0; mduty = duty_sel; ecl = 1'b1; efr = 1'b1;
    end else begin
      ecl = cl_data & (~cl_en | mt[cl_bit(mduty)]);
      efr = fr_data & (~fr_en | mt[9]);
      if (duty_sel != mduty) begin
        mduty = duty_sel; mt = '0;
      end else begin
        mt = mt + 10'd1;
      end
    end
  end

  always @(negedge clk) begin
    if (pin_chk) begin
      chk(cl_pin == ecl, "R6/R8/R9/R10 cl_pin", int'(cl_pin), int'(ecl));
      chk(fr_pin == efr, "R7/R8/R9/R10 fr_pin", int'(fr_pin), int'(efr));
    end
  end

  // period between rising edges of a pin, measured at negedges
  task automatic measure(input bit use_fr, output int period);
    logic prev, cur;
    int cnt;
    cnt = 0;
    @(negedge clk); prev = use_fr ? fr_pin : cl_pin;
    forever begin
      @(negedge clk); cur = use_fr ? fr_pin : cl_pin;
      if (cur && !prev) break;
      prev = cur;
    end
    prev = cur;
    forever begin
      @(negedge clk); cur = use_fr ? fr_pin : cl_pin; cnt++;
      if (cur && !prev) break;
      prev = cur;
    end
    period = cnt;
  endtask

  task automatic write_mode(input logic [1:0] m, input bit slp);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = m; sleep = slp;
    @(negedge clk);
    mode_we = 1'b0; sleep = 1'b0;
  endtask

  task automatic check_flags(input logic [1:0] m);
    chk(disp_mode == m, "R1 disp_mode", int'(disp_mode), int'(m));
    chk(static_com == (m == 2'b11), "R3 static_com", int'(static_com), int'(m == 2'b11));
    chk(dots_all_on == (m == 2'b11), "R3 dots_all_on", int'(dots_all_on), int'(m == 2'b11));
    chk(dots_all_off == (m == 2'b10), "R3 dots_all_off", int'(dots_all_off), int'(m == 2'b10));
    chk(drive_en == (m != 2'b00), "R3 drive_en", int'(drive_en), int'(m != 2'b00));
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int per;
    repeat (3) @(negedge clk);
    // reset state
    chk(cl_pin == 1'b1, "R9 reset cl_pin", int'(cl_pin), 1);
    chk(fr_pin == 1'b1, "R9 reset fr_pin", int'(fr_pin), 1);
    check_flags(2'b00);
    chk(contrast_out == 4'h0, "R4 reset contrast", int'(contrast_out), 0);
    rst = 1'b0;
    pin_chk = 1'b1;

    // duty sweep with both strobes enabled
    cl_en = 1'b1; fr_en = 1'b1;
    for (int d = 0; d < 4; d++) begin
      @(negedge clk); duty_sel = 2'(d);
      measure(1'b0, per);
      chk(per == (16 << ((d > 2) ? 2 : d)), "R6 cl period", per, 16 << ((d > 2) ? 2 : d));
      measure(1'b1, per);
      chk(per == 1024, "R7 fr period", per, 1024);
    end

    // mid-run duty change reloads the counter (model checks R8)
    @(negedge clk); duty_sel = 2'b01;
    repeat (37) @(negedge clk);
    duty_sel = 2'b00;
    repeat (100) @(negedge clk);

    // enable / data sweep at arbitrary phases
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      {cl_data, cl_en, fr_data, fr_en} = 4'(k);
      repeat (13 + k) @(negedge clk);
    end
    cl_data = 1'b1; fr_data = 1'b1; cl_en = 1'b0; fr_en = 1'b0;
    repeat (5) @(negedge clk);

    // mid-run reset clears the counter and idles pins high
    @(negedge clk); rst = 1'b1; cl_en = 1'b1; fr_en = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (40) @(negedge clk);

    // display modes
    for (int m = 3; m >= 0; m--) begin
      write_mode(2'(m), 1'b0);
      check_flags(2'(m));
      repeat (3) @(negedge clk);
      check_flags(2'(m));
    end
    write_mode(2'b01, 1'b0);
    check_flags(2'b01);
    write_mode(2'b11, 1'b1);
    chk(disp_mode == 2'b00, "R2 sleep beats write", int'(disp_mode), 0);
    check_flags(2'b00);
    write_mode(2'b10, 1'b0);
    @(negedge clk); sleep = 1'b1;
    @(negedge clk); sleep = 1'b0;
    chk(disp_mode == 2'b00, "R2 sleep forces off", int'(disp_mode), 0);

    // contrast codes, strap low then high
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); contrast_we = 1'b1; contrast_wdata = 4'(c); ext_supply = 1'b0;
      @(negedge clk); contrast_we = 1'b0;
      chk(contrast_out == 4'(c), "R4 contrast code", int'(contrast_out), c);
      ext_supply = 1'b1;
      @(negedge clk);
      chk(contrast_out == 4'h0, "R5 ext supply fixed", int'(contrast_out), 0);
      @(negedge clk); contrast_we = 1'b1; contrast_wdata = ~4'(c);
      @(negedge clk); contrast_we = 1'b0;
      chk(contrast_out == 4'h0, "R5 write under strap", int'(contrast_out), 0);
      ext_supply = 1'b0;
      @(negedge clk);
      chk(contrast_out == ~4'(c), "R5 stored code returns", int'(contrast_out), int'(~4'(c)));
    end

    done = 1'b1;
    pin_chk = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule